// File: doc/BRIEF.md
# Embedded-Sync Video Input Decoder with Frame Size Gate

This block sits right after an HDMI-class video receiver. It runs on the receiver's pixel clock and takes one 16-bit 4:2:2 word per clock. The upper byte carries luma (Y). The lower byte carries chroma, with Cb on even pixels and Cr on odd pixels. Line and frame timing are not sent on separate wires. Instead they are taken from four-word timing codes embedded in the data. The block counts the active pixels on each line and the active lines in each frame. When a frame closes, it compares those counts with an expected width and height given on input ports.

Pixels leave through a valid/ready stream toward a DMA engine. Each pixel is either 24-bit RGB or the raw input word. The first pixel of each frame carries a start-of-frame marker, and the last pixel of each line carries an end-of-line marker. RGB is produced by interpolating the chroma from 4:2:2 to 4:4:4 and then converting colour space.

The block forwards a frame only when the frame just before it closed with the expected size. This keeps wrong-length frames from reaching the DMA engine. A small buffer absorbs short stalls on the output. When the buffer is full, further pixels are dropped.

Top module: `vid_rx_sizegate`

## Requirements
- R1: A timing code is recognised only in this form:
  - Three successive upper bytes 0xFF, 0x00, 0x00, followed by a fourth upper byte with bit 7 set. In that byte, bit 6 = F, bit 5 = V, bit 4 = H.
  - Its low bits must satisfy b3 = V^H, b2 = F^H, b1 = F^V, b0 = F^V^H.
  - A preamble followed by a word with inconsistent low bits changes no timing, no measurement and no output.
- R2: A code with H=0 and V=0 opens an active line. Every following word up to, but not including, the next word whose upper byte is 0xFF is an active pixel. The active width of the line is the count of those words.
- R3: A frame opens at the first line-opening code received after reset or after the previous frame closed. It closes at the first code with V=1 while open. On close, `meas_width` takes the width of the frame's first line and `meas_height` takes the number of lines. Neither output changes at any other time.
- R4: A closed frame matches when three conditions hold: all of its lines have equal width, that width equals `exp_width`, and its line count equals `exp_height`. A frame that does not match sets `mismatch`. `mismatch` then stays set until `mismatch_clr` is pulsed. If a set and a clear arrive in the same cycle, the set wins.
- R5: A frame is forwarded only when the most recently closed frame matched. After reset, no pixel is forwarded until one matching frame has been received. Eligibility changes only at frame boundaries.
- R6: With `bypass` low, each pixel is converted with c=Y-16, d=Cb-128, e=Cr-128:
  - R = sat((298c+409e+128)>>8)
  - G = sat((298c-100d-208e+128)>>8)
  - B = sat((298c+516d+128)>>8)
  - `sat` clamps to the range 0..255.
  - The output is packed as {R[23:16], G[15:8], B[7:0]}.
- R7: Line widths are even, and word 2k gives Cb_k while word 2k+1 gives Cr_k.
  - Pixel 2k uses (Cb_k, Cr_k).
  - Pixel 2k+1 uses the rounded means (a+b+1)>>1 of Cb_k with Cb_k+1 and of Cr_k with Cr_k+1.
  - In the last pair of a line, pixel 2k+1 uses (Cb_k, Cr_k).
- R8: With `bypass` high, each output pixel is {8'h00, input word}, with no chroma processing.
- R9: `m_sof` is high only on pixel 0 of a forwarded frame. `m_eol` is high only on the last pixel of each line.
- R10: A beat transfers when `m_valid` and `m_ready` are both high. While `m_valid` is high and `m_ready` is low, `m_data`, `m_sof` and `m_eol` hold their values. Pixels leave in arrival order.
- R11: Up to FIFO_DEPTH pixels (default 1024) wait for `m_ready`. A pixel produced while the buffer is full is discarded, and the pixels already stored are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock from the video receiver |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_data | input | 16 | Input word: Y in [15:8], Cb/Cr in [7:0] |
| bypass | input | 1 | Pass raw words instead of converting to RGB |
| exp_width | input | WW | Expected active pixels per line |
| exp_height | input | HW | Expected active lines per frame |
| mismatch_clr | input | 1 | Clears the sticky mismatch flag |
| meas_width | output | WW | First-line width of the last closed frame |
| meas_height | output | HW | Line count of the last closed frame |
| mismatch | output | 1 | Sticky: a closed frame did not match |
| m_valid | output | 1 | Output pixel available |
| m_ready | input | 1 | Downstream accepts the pixel |
| m_data | output | 24 | RGB or raw pixel |
| m_sof | output | 1 | First pixel of a frame |
| m_eol | output | 1 | Last pixel of a line |

## Verification
Three situations are hard to reach from the ports:

- **A full buffer.** This happens only when a frame larger than the buffer arrives while the consumer stays stalled. The stimulus first programs and sends a 64x20 frame so that the gate is armed for that size. It then sends a second frame of the same size with `m_ready` held low the whole time, and drains afterwards. Exactly the leading FIFO_DEPTH pixels must appear.
- **A single-line width error.** The gate decision must follow the previous frame rather than the current one, and a width error may sit in just one line. A ragged frame and a short frame are therefore each sent while the gate is armed, and each is followed by a correctly sized frame that must be withheld.
- **A bad protection word.** Malformed codes are covered by frames whose line-opening codes have bad protection bits.

// File: rtl/vid_rx_pkg.sv
package vid_rx_pkg;

  // Consistency of a timing code word: marker bit plus protection bits.
  function automatic logic sync_prot_ok(input logic [7:0] c);
    return c[7] && (c[3] == (c[5] ^ c[4])) && (c[2] == (c[6] ^ c[4])) &&
           (c[1] == (c[6] ^ c[5])) && (c[0] == (c[6] ^ c[5] ^ c[4]));
  endfunction

  // Rounded mean of two chroma samples.
  function automatic logic [7:0] chroma_mean(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b} + 9'd1;
    return s[8:1];
  endfunction

  function automatic logic [7:0] sat8(input int v);
    if (v < 0) return 8'd0;
    if (v > 255) return 8'd255;
    return 8'(v);
  endfunction

  // Studio-range YCbCr to full-range RGB, packed {R,G,B}.
  function automatic logic [23:0] ycc_to_rgb(input logic [7:0] y, input logic [7:0] cb,
                                            input logic [7:0] cr);
    int c, d, e;
    c = int'(y) - 16;
    d = int'(cb) - 128;
    e = int'(cr) - 128;
    return {sat8((298 * c + 409 * e + 128) >>> 8),
            sat8((298 * c - 100 * d - 208 * e + 128) >>> 8),
            sat8((298 * c + 516 * d + 128) >>> 8)};
  endfunction

endpackage

// File: rtl/vid_sync_decode.sv
module vid_sync_decode
  import vid_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] y_in,
  output logic       code_hit,
  output logic       code_v,
  output logic       code_h,
  output logic       act_word,
  output logic       line_end
);
  logic [7:0] y1, y2, y3;
  logic       line_act;

  assign code_hit = (y3 == 8'hFF) && (y2 == 8'h00) && (y1 == 8'h00) && sync_prot_ok(y_in);
  assign code_v   = y_in[5];
  assign code_h   = y_in[4];
  assign act_word = line_act && (y_in != 8'hFF);
  assign line_end = line_act && (y_in == 8'hFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      y1 <= '0;
      y2 <= '0;
      y3 <= '0;
      line_act <= 1'b0;
    end else begin
      y1 <= y_in;
      y2 <= y1;
      y3 <= y2;
      if (code_hit && !code_h && !code_v) line_act <= 1'b1;
      else if (line_end)                 line_act <= 1'b0;
    end
  end
endmodule

// File: rtl/vid_pix_chroma.sv
module vid_pix_chroma
  import vid_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bypass,
  input  logic        line_start,
  input  logic        act_word,
  input  logic        line_end,
  input  logic [15:0] word,
  output logic        px_valid,
  output logic [23:0] px_data,
  output logic        px_first,
  output logic        px_last
);
  logic [15:0] pa_w0, pa_w1, nb_w;
  logic        pa_valid, par, flush, first_pend;
  logic        emit, e_last;
  logic [15:0] e_w;
  logic [7:0]  e_cb, e_cr;

  // Output is two words behind the input so odd pixels can see the next pair.
  always_comb begin
    emit   = 1'b0;
    e_w    = pa_w0;
    e_cb   = pa_w0[7:0];
    e_cr   = pa_w1[7:0];
    e_last = 1'b0;
    if (act_word && pa_valid) begin
      emit = 1'b1;
      if (par) begin
        e_w  = pa_w1;
        e_cb = chroma_mean(pa_w0[7:0], nb_w[7:0]);
        e_cr = chroma_mean(pa_w1[7:0], word[7:0]);
      end
    end else if (line_end && pa_valid) begin
      emit = 1'b1;
    end else if (flush) begin
      emit   = 1'b1;
      e_w    = pa_w1;
      e_last = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pa_w0 <= '0;
      pa_w1 <= '0;
      nb_w <= '0;
      pa_valid <= 1'b0;
      par <= 1'b0;
      flush <= 1'b0;
      first_pend <= 1'b0;
      px_valid <= 1'b0;
      px_data <= '0;
      px_first <= 1'b0;
      px_last <= 1'b0;
    end else begin
      px_valid <= emit;
      if (emit) begin
        px_data  <= bypass ? {8'h00, e_w} : ycc_to_rgb(e_w[15:8], e_cb, e_cr);
        px_first <= first_pend;
        px_last  <= e_last;
      end
      if (line_start) begin
        pa_valid   <= 1'b0;
        par        <= 1'b0;
        flush      <= 1'b0;
        first_pend <= 1'b1;
      end else begin
        if (emit) first_pend <= 1'b0;
        if (act_word) begin
          if (!par) nb_w <= word;
          else begin
            pa_w0    <= nb_w;
            pa_w1    <= word;
            pa_valid <= 1'b1;
          end
          par <= ~par;
        end
        flush <= line_end && pa_valid;
        if (flush) pa_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vid_px_fifo.sv
module vid_px_fifo #(
  parameter int DW    = 26,
  parameter int DEPTH = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          full,
  input  logic          rd_en,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_wr, do_rd;

  assign full     = (cnt == CW'(DEPTH));
  assign rd_valid = (cnt != '0);
  assign rd_data  = mem[rp];
  assign do_wr    = wr_en && !full;
  assign do_rd    = rd_en && rd_valid;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(do_wr) - CW'(do_rd);
    end
  end
endmodule

// File: rtl/vid_rx_sizegate.sv
module vid_rx_sizegate #(
  parameter int WW         = 12,
  parameter int HW         = 12,
  parameter int FIFO_DEPTH = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   vid_data,
  input  logic          bypass,
  input  logic [WW-1:0] exp_width,
  input  logic [HW-1:0] exp_height,
  input  logic          mismatch_clr,
  output logic [WW-1:0] meas_width,
  output logic [HW-1:0] meas_height,
  output logic          mismatch,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [23:0]   m_data,
  output logic          m_sof,
  output logic          m_eol
);
  localparam int FDW = 26;

  logic code_hit, code_v, code_h, act_word, line_end;
  logic line_start, frame_start, frame_end, frame_match;
  logic in_frame, armed, fwd, ragged, sof_pend;
  logic [WW-1:0] wcnt, wfirst;
  logic [HW-1:0] hcnt;
  logic          px_valid, px_first, px_last, fifo_wr, fifo_full;
  logic [23:0]   px_data;
  logic [FDW-1:0] fifo_out;

  vid_sync_decode u_sync (
    .clk(clk), .rst_n(rst_n), .y_in(vid_data[15:8]),
    .code_hit(code_hit), .code_v(code_v), .code_h(code_h),
    .act_word(act_word), .line_end(line_end)
  );

  assign line_start  = code_hit && !code_h && !code_v;
  assign frame_start = line_start && !in_frame;
  assign frame_end   = code_hit && code_v && in_frame;
  assign frame_match = !ragged && (wfirst == exp_width) && (hcnt == exp_height);

  vid_pix_chroma u_chroma (
    .clk(clk), .rst_n(rst_n), .bypass(bypass), .line_start(line_start),
    .act_word(act_word), .line_end(line_end), .word(vid_data),
    .px_valid(px_valid), .px_data(px_data), .px_first(px_first), .px_last(px_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      armed <= 1'b0;
      fwd <= 1'b0;
      ragged <= 1'b0;
      sof_pend <= 1'b0;
      wcnt <= '0;
      wfirst <= '0;
      hcnt <= '0;
      meas_width <= '0;
      meas_height <= '0;
      mismatch <= 1'b0;
    end else begin
      if (line_start)    wcnt <= '0;
      else if (act_word) wcnt <= wcnt + 1'b1;

      if (frame_start) begin
        in_frame <= 1'b1;
        fwd      <= armed;
        hcnt     <= '0;
        ragged   <= 1'b0;
        sof_pend <= 1'b1;
      end else if (line_end) begin
        hcnt <= hcnt + 1'b1;
        if (hcnt == '0)          wfirst <= wcnt;
        else if (wcnt != wfirst) ragged <= 1'b1;
      end

      if (px_valid && px_first) sof_pend <= 1'b0;

      if (frame_end) begin
        in_frame    <= 1'b0;
        fwd         <= 1'b0;
        armed       <= frame_match;
        meas_width  <= wfirst;
        meas_height <= hcnt;
      end

      if (frame_end && !frame_match) mismatch <= 1'b1;
      else if (mismatch_clr)         mismatch <= 1'b0;
    end
  end

  assign fifo_wr = px_valid && fwd;

  vid_px_fifo #(.DW(FDW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(fifo_wr),
    .wr_data({px_valid && px_first && sof_pend, px_last, px_data}),
    .full(fifo_full), .rd_en(m_ready), .rd_valid(m_valid), .rd_data(fifo_out)
  );

  assign m_sof  = fifo_out[25];
  assign m_eol  = fifo_out[24];
  assign m_data = fifo_out[23:0];
endmodule

// File: rtl/vid_rx_sizegate_chk.sv
module vid_rx_sizegate_chk #(
  parameter int WW = 12,
  parameter int HW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          m_valid,
  input logic          m_ready,
  input logic [23:0]   m_data,
  input logic          m_sof,
  input logic          m_eol,
  input logic [WW-1:0] meas_width,
  input logic [HW-1:0] meas_height,
  input logic          mismatch,
  input logic          mismatch_clr,
  input logic          frame_start,
  input logic          frame_end,
  input logic          frame_match,
  input logic          fwd,
  input logic          armed
);
  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_sof) && $stable(m_eol));

  a_r4_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && !frame_match |=> mismatch);

  a_r4_sticky_keep: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch && !mismatch_clr |=> mismatch);

  a_r3_meas_only_at_close: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(meas_width) && $stable(meas_height));

  a_r5_fwd_opens_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fwd) |-> $past(frame_start));

  a_r5_arm_after_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(frame_end && frame_match));
endmodule

bind vid_rx_sizegate vid_rx_sizegate_chk #(.WW(WW), .HW(HW)) chk_i (
  .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
  .m_sof(m_sof), .m_eol(m_eol), .meas_width(meas_width), .meas_height(meas_height),
  .mismatch(mismatch), .mismatch_clr(mismatch_clr), .frame_start(frame_start),
  .frame_end(frame_end), .frame_match(frame_match), .fwd(fwd), .armed(armed)
);

// File: tb/vid_rx_sizegate_tb_top.sv
module vid_rx_sizegate_tb_top;
  localparam int WW = 12, HW = 12, DEPTH = 1024, QN = 4096;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] vid_data = 16'h1080;
  logic bypass = 1'b0, mismatch_clr = 1'b0, m_ready = 1'b1;
  logic [WW-1:0] exp_width = 12'd8;
  logic [HW-1:0] exp_height = 12'd4;
  logic [WW-1:0] meas_width;
  logic [HW-1:0] meas_height;
  logic mismatch, m_valid, m_sof, m_eol;
  logic [23:0] m_data;

  int n_chk = 0, n_bad = 0, rdy_mode = 0, gcnt = 0, ecnt = 0;
  bit bm_armed = 1'b0, done = 1'b0;
  logic [25:0] got_q [QN];
  logic [25:0] exp_q [QN];

  always #2.5 clk = ~clk;

  vid_rx_sizegate #(.WW(WW), .HW(HW), .FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .vid_data(vid_data), .bypass(bypass),
    .exp_width(exp_width), .exp_height(exp_height), .mismatch_clr(mismatch_clr),
    .meas_width(meas_width), .meas_height(meas_height), .mismatch(mismatch),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_sof(m_sof), .m_eol(m_eol)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // ready driver
  initial begin
    int c = 0;
    forever begin
      @(posedge clk); #1;
      c++;
      m_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? 1'b0 : ((c % 3) != 0);
    end
  end

  // output monitor, sampled mid-cycle
  initial begin
    bit hold = 1'b0;
    logic [25:0] prev = '0;
    forever begin
      @(negedge clk);
      if (rst_n && hold)
        chk(m_valid && {m_sof, m_eol, m_data} == prev, "R10 hold", {m_sof, m_eol, m_data}, prev);
      hold = rst_n && m_valid && !m_ready;
      prev = {m_sof, m_eol, m_data};
      if (rst_n && m_valid && m_ready) begin
        if (gcnt < QN) got_q[gcnt] = {m_sof, m_eol, m_data};
        gcnt++;
      end
    end
  end

  function automatic int sat(input int x);
    int t = x + 128;
    if (t < 0) return 0;
    t = t / 256;
    return (t > 255) ? 255 : t;
  endfunction

  function automatic logic [23:0] ref_rgb(input int y, input int cb, input int cr);
    int r, g, b;
    r = sat(298 * (y - 16) + 409 * (cr - 128));
    g = sat(298 * (y - 16) - 100 * (cb - 128) - 208 * (cr - 128));
    b = sat(298 * (y - 16) + 516 * (cb - 128));
    return {r[7:0], g[7:0], b[7:0]};
  endfunction

  function automatic logic [15:0] wgen(input int seed, input int l, input int i);
    int y = 16 + (seed * 7 + i * 13 + l * 29) % 200;
    int c = 16 + (seed * 11 + i * 37 + l * 3) % 220;
    return {y[7:0], c[7:0]};
  endfunction

  task automatic put(input logic [15:0] w);
    vid_data = w;
    @(posedge clk); #1;
  endtask

  task automatic code(input bit f, input bit v, input bit h, input bit bad);
    logic [7:0] xy = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h ^ bad};
    put(16'hFFFF); put(16'h0000); put(16'h0000); put({xy, xy});
  endtask

  task automatic blank(input int n);
    for (int k = 0; k < n; k++) put(16'h1080);
  endtask

  // One frame: h active lines, then a vertical blanking region. Model runs alongside.
  task automatic send_frame(input int w, input int h, input int seed, input bit bad,
                            input int rag_line, input int rag_w);
    bit match = !bad && rag_line < 0 && w == int'(exp_width) && h == int'(exp_height);
    for (int l = 0; l < h; l++) begin
      int lw = (l == rag_line) ? rag_w : w;
      code(1'b0, 1'b0, 1'b0, bad);
      for (int i = 0; i < lw; i++) put(wgen(seed, l, i));
      code(1'b0, 1'b0, 1'b1, 1'b0);
      blank(6);
      if (!bad && bm_armed) begin
        for (int i = 0; i < lw; i++) begin
          logic [15:0] wd = wgen(seed, l, i);
          int k = i / 2;
          int cb = wgen(seed, l, 2 * k) & 255;
          int cr = wgen(seed, l, 2 * k + 1) & 255;
          logic [23:0] px;
          if ((i % 2) == 1 && 2 * k + 2 < lw) begin
            cb = (cb + (wgen(seed, l, 2 * k + 2) & 255) + 1) / 2;
            cr = (cr + (wgen(seed, l, 2 * k + 3) & 255) + 1) / 2;
          end
          px = bypass ? {8'h00, wd} : ref_rgb(int'(wd[15:8]), cb, cr);
          if (ecnt < QN) exp_q[ecnt] = {(l == 0 && i == 0), (i == lw - 1), px};
          ecnt++;
        end
      end
    end
    code(1'b0, 1'b1, 1'b1, 1'b0); blank(6);
    code(1'b0, 1'b1, 1'b0, 1'b0); blank(4);
    code(1'b0, 1'b1, 1'b1, 1'b0); blank(4);
    if (!bad) bm_armed = match;
  endtask

  task automatic drain();
    for (int k = 0; k < 6000 && (m_valid || rdy_mode != 0); k++) begin
      if (!m_valid) break;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic clr_rec();
    gcnt = 0; ecnt = 0;
  endtask

  task automatic cmp_stream(input string req, input int n);
    chk(gcnt == n, {req, " beat count"}, gcnt, n);
    for (int i = 0; i < n && i < gcnt && i < QN; i++)
      chk(got_q[i] == exp_q[i], {req, " pixel"}, got_q[i], exp_q[i]);
  endtask

  task automatic t_reset();
    chk(!m_valid, "R5 reset valid", m_valid, 0);
    chk(meas_width == 0 && meas_height == 0, "R3 reset meas", {meas_width, meas_height}, 0);
    chk(!mismatch, "R4 reset sticky", mismatch, 0);
  endtask

  task automatic t_unarmed();
    clr_rec();
    send_frame(8, 4, 1, 1'b0, -1, 0); drain();
    chk(gcnt == 0, "R5 first frame withheld", gcnt, 0);
    chk(meas_width == 8, "R3 width", meas_width, 8);
    chk(meas_height == 4, "R3 height", meas_height, 4);
    chk(!mismatch, "R4 match no sticky", mismatch, 0);
  endtask

  task automatic t_convert();
    clr_rec();
    send_frame(8, 4, 2, 1'b0, -1, 0); drain();
    cmp_stream("R6 R7 R9 R2 convert", 32);
  endtask

  task automatic t_bypass();
    clr_rec(); bypass = 1'b1;
    send_frame(8, 4, 3, 1'b0, -1, 0); drain();
    cmp_stream("R8 bypass", 32);
    bypass = 1'b0;
  endtask

  task automatic t_bad_code();
    clr_rec(); exp_width = 12'd6; exp_height = 12'd2;
    send_frame(6, 2, 4, 1'b1, -1, 0); drain();
    chk(gcnt == 0, "R1 bad code no output", gcnt, 0);
    chk(meas_width == 8 && meas_height == 4, "R1 bad code meas kept",
        {meas_width, meas_height}, {12'd8, 12'd4});
    exp_width = 12'd8; exp_height = 12'd4;
    send_frame(8, 4, 5, 1'b0, -1, 0); drain();
    cmp_stream("R1 arming kept", 32);
  endtask

  task automatic t_mismatch();
    clr_rec();
    send_frame(8, 3, 6, 1'b0, -1, 0); drain();
    cmp_stream("R5 armed short frame", 24);
    chk(mismatch, "R4 short sets sticky", mismatch, 1);
    chk(meas_height == 3, "R3 short height", meas_height, 3);
    clr_rec();
    send_frame(8, 4, 7, 1'b0, -1, 0); drain();
    chk(gcnt == 0, "R5 after mismatch withheld", gcnt, 0);
    chk(mismatch, "R4 sticky holds", mismatch, 1);
    mismatch_clr = 1'b1; @(posedge clk); #1; mismatch_clr = 1'b0;
    chk(!mismatch, "R4 clear", mismatch, 0);
    clr_rec();
    send_frame(8, 4, 8, 1'b0, 2, 6); drain();
    cmp_stream("R7 ragged frame pixels", 30);
    chk(mismatch, "R4 ragged sets sticky", mismatch, 1);
    chk(meas_width == 8, "R3 first line width", meas_width, 8);
    clr_rec();
    send_frame(8, 4, 9, 1'b0, -1, 0); drain();
    chk(gcnt == 0, "R5 after ragged withheld", gcnt, 0);
    mismatch_clr = 1'b1; @(posedge clk); #1; mismatch_clr = 1'b0;
  endtask

  task automatic t_backpressure();
    clr_rec(); rdy_mode = 2;
    send_frame(8, 4, 10, 1'b0, -1, 0); drain();
    rdy_mode = 0; drain();
    cmp_stream("R10 stalled stream", 32);
  endtask

  task automatic t_overflow();
    exp_width = 12'd64; exp_height = 12'd20;
    send_frame(64, 20, 11, 1'b0, -1, 0); drain();
    chk(bm_armed && !mismatch, "R11 armed for large frame", mismatch, 0);
    clr_rec(); rdy_mode = 1;
    send_frame(64, 20, 12, 1'b0, -1, 0);
    repeat (8) @(posedge clk); #1;
    rdy_mode = 0; drain();
    cmp_stream("R11 overflow keeps leading pixels", DEPTH);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_unarmed();
    t_convert();
    t_bypass();
    t_bad_code();
    t_mismatch();
    t_backpressure();
    t_overflow();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule